// File: doc/BRIEF.md
# Rotating Interrupt Priority Resolver

This block decides which interrupt input, if any, an eight-input interrupt controller should present to the processor. It takes the controller's current pending, masked and in-service bit sets and a rotation offset. It finds the highest-priority pending input that is not masked, then lets that input through only when it outranks everything currently in service. The decision logic is purely combinational and settles within one cycle.

Priority is circular. The offset names the input that sits at the top priority level, and the other inputs follow in increasing input-number order, wrapping around. When a controller is the master of a cascade and runs in special nested mode, the in-service bit of the cascade input (input 2) is left out of the comparison. This lets a further request from the slave reach the processor while an earlier slave request is still being serviced.

A thin harness registers the two outputs so that the resolver can be placed in a clocked pipeline and exercised at a clock edge. Storage of the bit sets, command decoding and the cascade wiring are not part of this block.

Top module: `rpr_top`

## Requirements
- R1: Only requests whose mask bit is 0 are candidates (candidates = req_i AND NOT mask_i). A request with its mask bit set never wins.
- R2: Priority level p belongs to input number (p + rot_i) mod 8, and level 0 is the highest. Among the candidates, the one at the lowest level wins.
- R3: When there is no candidate, hit_o is 0.
- R4: A candidate wins only if its level is strictly smaller than the level of the highest-priority in-service bit. An input that is in service blocks itself and every input at a lower priority. An empty in-service set blocks nothing.
- R5: When nest_en_i and is_master_i are both 1, in-service bit 2 is ignored in the comparison of R4.
- R6: When either nest_en_i or is_master_i is 0, in-service bit 2 takes part in the comparison like any other bit.
- R7: line_o gives the input number (0 to 7) of the winner when hit_o is 1, and is 0 when hit_o is 0.
- R8: hit_o and line_o are registered. They reflect the inputs present at the preceding rising clock edge. A synchronous active-low reset clears both to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output registers |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 8 | Pending request bits, bit n for input n |
| mask_i | input | 8 | Mask bits, 1 disables input n |
| insvc_i | input | 8 | In-service bits, bit n for input n |
| rot_i | input | 3 | Input number that holds priority level 0 |
| nest_en_i | input | 1 | Special nested mode enable |
| is_master_i | input | 1 | This instance is the cascade master |
| hit_o | output | 1 | An interrupt should be presented |
| line_o | output | 3 | Input number of the winner, 0 when no hit |

## Verification
The embedded assertions check on every cycle that a reported winner was an unmasked pending request one cycle earlier, and that it was not itself in service except under the nested-mode exemption for input 2. They also check that no hit follows an empty candidate set, that the index reads zero when idle, and that reset clears the outputs. Choosing the right winner under rotation, and blocking by a higher in-service input at a different position, can only be confirmed by comparing against the bench's reference model. That comparison runs over directed wrap-around and nested-mode cases and over random patterns.

// File: rtl/rpr_pkg.sv
// Shared sizing for the rotating priority resolver.
// Assumes LINES is a power of two, so that rotation wraps by truncation.
package rpr_pkg;
    localparam int unsigned LINES        = 8;
    localparam int unsigned IDX_W        = $clog2(LINES);
    localparam int unsigned LVL_W        = $clog2(LINES + 1);
    localparam int unsigned CASCADE_LINE = 2;
endpackage

// File: rtl/rpr_rotator.sv
// Maps a per-input bit vector onto priority levels: bit p of the result is
// bit ((p + off_i) mod N) of the input. Assumes N is a power of two.
module rpr_rotator #(
    parameter int unsigned N = 8,
    localparam int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  vec_i,
    input  logic [IW-1:0] off_i,
    output logic [N-1:0]  lvl_o
);
    for (genvar p = 0; p < N; p++) begin : g_lvl
        logic [IW-1:0] src;
        // Source input for level p, wrapping modulo N.
        always_comb src = IW'(p) + off_i;
        assign lvl_o[p] = vec_i[src];
    end
endmodule

// File: rtl/rpr_first_set.sv
// Returns the index of the lowest set bit, or N when no bit is set.
// The search is written as an unrolled chain, so it has no state.
module rpr_first_set #(
    parameter int unsigned N = 8,
    localparam int unsigned LW = $clog2(N + 1)
) (
    input  logic [N-1:0]  vec_i,
    output logic [LW-1:0] lvl_o
);
    // Scan from the top so that the lowest set bit is written last.
    always_comb begin
        lvl_o = LW'(N);
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) lvl_o = LW'(i);
        end
    end
endmodule

// File: rtl/rpr_resolver.sv
// Combinational decision: best unmasked request against best in-service level.
// Assumes that rot_i names the input at level 0 and that N is a power of two.
module rpr_resolver
    import rpr_pkg::*;
#(
    parameter int unsigned N = LINES,
    localparam int unsigned IW = $clog2(N),
    localparam int unsigned LW = $clog2(N + 1)
) (
    input  logic [N-1:0]  req_i,
    input  logic [N-1:0]  mask_i,
    input  logic [N-1:0]  insvc_i,
    input  logic [IW-1:0] rot_i,
    input  logic          nest_en_i,
    input  logic          is_master_i,
    output logic          hit_o,
    output logic [IW-1:0] line_o
);
    logic [N-1:0]  cand;
    logic [N-1:0]  isr_eff;
    logic [N-1:0]  cand_lvl;
    logic [N-1:0]  isr_lvl;
    logic [LW-1:0] best_req;
    logic [LW-1:0] best_isr;

    // Pending and not masked.
    always_comb cand = req_i & ~mask_i;

    // In-service set seen by the comparison; a nested master drops its cascade bit.
    always_comb begin
        isr_eff = insvc_i;
        if (nest_en_i && is_master_i) isr_eff[CASCADE_LINE] = 1'b0;
    end

    rpr_rotator #(.N(N)) u_rot_req (.vec_i(cand),    .off_i(rot_i), .lvl_o(cand_lvl));
    rpr_rotator #(.N(N)) u_rot_isr (.vec_i(isr_eff), .off_i(rot_i), .lvl_o(isr_lvl));

    rpr_first_set #(.N(N)) u_best_req (.vec_i(cand_lvl), .lvl_o(best_req));
    rpr_first_set #(.N(N)) u_best_isr (.vec_i(isr_lvl),  .lvl_o(best_isr));

    // Strictly higher priority than anything in service; best_isr <= N implies best_req < N.
    always_comb begin
        hit_o  = best_req < best_isr;
        line_o = hit_o ? (best_req[IW-1:0] + rot_i) : '0;
    end
endmodule

// File: rtl/rpr_top.sv
// Registered harness around the resolver. The outputs follow the inputs
// present at the previous rising edge. Reset is synchronous and active-low.
module rpr_top
    import rpr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] req_i,
    input  logic [LINES-1:0] mask_i,
    input  logic [LINES-1:0] insvc_i,
    input  logic [IDX_W-1:0] rot_i,
    input  logic             nest_en_i,
    input  logic             is_master_i,
    output logic             hit_o,
    output logic [IDX_W-1:0] line_o
);
    logic             hit_c;
    logic [IDX_W-1:0] line_c;

    rpr_resolver #(.N(LINES)) u_resolver (
        .req_i       (req_i),
        .mask_i      (mask_i),
        .insvc_i     (insvc_i),
        .rot_i       (rot_i),
        .nest_en_i   (nest_en_i),
        .is_master_i (is_master_i),
        .hit_o       (hit_c),
        .line_o      (line_c)
    );

    // Output register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_o  <= 1'b0;
            line_o <= '0;
        end else begin
            hit_o  <= hit_c;
            line_o <= line_c;
        end
    end

    function automatic logic bit_at(input logic [LINES-1:0] v, input logic [IDX_W-1:0] i);
        return v[i];
    endfunction

    p_reset_clears_r8: assert property (@(posedge clk)
        !rst_n |=> (!hit_o && line_o == '0));

    p_idle_index_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_o |-> line_o == '0);

    p_winner_unmasked_r1: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> bit_at($past(req_i & ~mask_i), line_o));

    p_empty_no_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(req_i & ~mask_i) == '0 && $past(rst_n)) |-> !hit_o);

    p_self_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> (!bit_at($past(insvc_i), line_o) ||
                   ($past(nest_en_i && is_master_i) && line_o == IDX_W'(CASCADE_LINE))));
endmodule

// File: tb/rpr_top_tb_top.sv
module rpr_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req = '0, mask = '0, isr = '0;
    logic [2:0] rot = '0;
    logic       nest = 1'b0, master = 1'b0;
    logic       hit;
    logic [2:0] line;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rpr_top dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req), .mask_i(mask), .insvc_i(isr),
        .rot_i(rot), .nest_en_i(nest), .is_master_i(master),
        .hit_o(hit), .line_o(line)
    );

    // Reference: scan levels from 0 for the first unmasked request and the first in-service bit.
    function automatic void ref_model(input logic [7:0] rq, mk, is, input logic [2:0] rt,
                                      input logic ne, ms, output logic eh, output logic [2:0] el);
        int rl = 8, il = 8;
        logic [7:0] c = rq & ~mk;
        logic [7:0] s = is;
        if (ne && ms) s[2] = 1'b0;
        for (int p = 7; p >= 0; p--) begin
            if (c[(p + rt) % 8]) rl = p;
            if (s[(p + rt) % 8]) il = p;
        end
        eh = rl < il;
        el = eh ? 3'((rl + rt) % 8) : 3'd0;
    endfunction

    task automatic check(input string tag, input logic eh, input logic [2:0] el);
        n_tests++;
        if (hit !== eh || line !== el) begin
            n_fail++;
            $display("FAIL %s: hit=%0d line=%0d expected hit=%0d line=%0d", tag, hit, line, eh, el);
        end
    endtask

    // Drive at a falling edge, let one rising edge capture, compare at the next falling edge.
    task automatic apply(input string tag, input logic [7:0] rq, mk, is, input logic [2:0] rt,
                         input logic ne, ms);
        logic eh; logic [2:0] el;
        req = rq; mask = mk; isr = is; rot = rt; nest = ne; master = ms;
        ref_model(rq, mk, is, rt, ne, ms, eh, el);
        @(posedge clk); @(negedge clk);
        check(tag, eh, el);
    endtask

    task automatic apply_exp(input string tag, input logic [7:0] rq, mk, is, input logic [2:0] rt,
                             input logic ne, ms, input logic eh, input logic [2:0] el);
        req = rq; mask = mk; isr = is; rot = rt; nest = ne; master = ms;
        @(posedge clk); @(negedge clk);
        check(tag, eh, el);
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        req = 8'hFF;
        repeat (3) @(negedge clk);
        check("R8 reset", 1'b0, 3'd0);
        rst_n = 1'b1;

        apply_exp("R3 no request",     8'h00, 8'h00, 8'h00, 3'd0, 0, 0, 1'b0, 3'd0);
        apply_exp("R1 all masked",     8'h3C, 8'h3C, 8'h00, 3'd0, 0, 0, 1'b0, 3'd0);
        apply_exp("R1 partly masked",  8'h0C, 8'h04, 8'h00, 3'd0, 0, 0, 1'b1, 3'd3);
        apply_exp("R2 no rotation",    8'h90, 8'h00, 8'h00, 3'd0, 0, 0, 1'b1, 3'd4);
        apply_exp("R2 rotated",        8'h90, 8'h00, 8'h00, 3'd5, 0, 0, 1'b1, 3'd7);
        apply_exp("R2 wrap",           8'h11, 8'h00, 8'h00, 3'd6, 0, 0, 1'b1, 3'd0);
        apply_exp("R4 self in service",8'h08, 8'h00, 8'h08, 3'd0, 0, 0, 1'b0, 3'd0);
        apply_exp("R4 higher in svc",  8'h20, 8'h00, 8'h02, 3'd0, 0, 0, 1'b0, 3'd0);
        apply_exp("R4 lower in svc",   8'h02, 8'h00, 8'h20, 3'd0, 0, 0, 1'b1, 3'd1);
        apply_exp("R4 rotated block",  8'h01, 8'h00, 8'h40, 3'd6, 0, 0, 1'b0, 3'd0);
        apply_exp("R5 nested master",  8'h04, 8'h00, 8'h04, 3'd0, 1, 1, 1'b1, 3'd2);
        apply_exp("R5 nested lower",   8'h08, 8'h00, 8'h04, 3'd0, 1, 1, 1'b1, 3'd3);
        apply_exp("R6 nested slave",   8'h04, 8'h00, 8'h04, 3'd0, 1, 0, 1'b0, 3'd0);
        apply_exp("R6 master no nest", 8'h08, 8'h00, 8'h04, 3'd0, 0, 1, 1'b0, 3'd0);
        apply_exp("R7 input seven",    8'h80, 8'h00, 8'h00, 3'd7, 0, 0, 1'b1, 3'd7);

        for (int k = 0; k < 3000; k++) begin
            apply("R2 R4 R5 R7 random", 8'($urandom), 8'($urandom) & 8'($urandom),
                  8'($urandom) & 8'($urandom), 3'($urandom), 1'($urandom), 1'($urandom));
        end

        req = 8'hFF; mask = 8'h00; isr = 8'h00;
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R8 reset again", 1'b0, 3'd0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule